// File: doc/BRIEF.md
# Clock Source Selection Calculator

This block decides how a clock domain should be produced for a requested frequency in kHz. Three frequencies have their own fixed sources and map straight to a select code. Any other request is tried against a post-divider on the current VCO output. If the divided frequency lands close enough to the request, or if no PLL exists to fall back on, the divider setting is used. Otherwise the block raises a flag asking for PLL coefficients. If no usable divider exists and no PLL is attached, it reports an out-of-range error.

A request is presented with a one-cycle `start` pulse. The block latches its inputs and runs two divisions in turn on one shared restoring divider: first the divider estimate, then the achieved frequency. It returns a one-cycle `done` pulse. The results stay on the outputs until the next request completes.

Top module: `clk_src_select`

## Requirements
- R1: A request of exactly 27000, 100000 or 108000 kHz returns select code 0x100, 0x2100 or 0x2140 in that order. The achieved frequency equals the request, and both flags are 0.
- R2: For any other request the estimate E is min(floor(2·VCO / (target − 2999)), 65). E is 0 when the target is below 3000.
- R3: The divider path is considered only when E > 4. Its achieved frequency is floor(2·VCO / E).
- R4: A considered divider is accepted when no PLL is attached, or when target − achieved, taken as a signed value, lies in [−2000, 3000).
- R5: An accepted divider returns select code ((E − 2) << 16) | 0x3100 with both flags 0. The divider field therefore sits in bits 21:16 and the source field 0b11 in bits 13:12.
- R6: When the divider is not accepted, an attached PLL gives need_pll=1, and a missing PLL gives range_err=1. In both cases the select code and achieved frequency are 0.
- R7: `start` is taken only while the block is idle. `done` is a single-cycle pulse. The outputs hold their values from one `done` to the next, and a `start` during a calculation does not change its result.
- R8: After reset, done, sel_code, achieved_khz, need_pll and range_err are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, sampled while idle |
| target_khz | input | FW | Requested frequency |
| vco_khz | input | FW | Current VCO frequency |
| pll_attached | input | 1 | A PLL can serve this domain |
| done | output | 1 | One-cycle result pulse |
| sel_code | output | 32 | Select-register code |
| achieved_khz | output | FW | Frequency the code produces |
| need_pll | output | 1 | PLL coefficients must be computed |
| range_err | output | 1 | No source can serve the request |

## Verification
The divider is reused for two different divisions, so a wrong state or remainder carried over from one to the next shows up at the ports. It gives a wrong divider field or achieved frequency in the same `done` pulse as the request that caused it. The requests sit on the edges of the acceptance window, the clamp at 65 and the E > 4 threshold. A wrong sign or width in the difference therefore flips need_pll or the select code within one request. A `start` arriving mid-calculation is checked by comparing the result it would have produced with the one the first request must produce.

// File: rtl/clk_src_select.sv
module clk_src_select #(
  parameter int FW      = 32,
  parameter int EST_MAX = 65,
  parameter int EST_MIN = 4,
  parameter int WIN_LO  = 2000,
  parameter int WIN_HI  = 3000,
  parameter int OFS     = 2999
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [FW-1:0] target_khz,
  input  logic [FW-1:0] vco_khz,
  input  logic          pll_attached,
  output logic          done,
  output logic [31:0]   sel_code,
  output logic [FW-1:0] achieved_khz,
  output logic          need_pll,
  output logic          range_err
);
  localparam int NW = FW + 1;
  localparam int CW = $clog2(NW + 1);
  localparam int EW = $clog2(EST_MAX + 1);
  localparam logic signed [NW-1:0] SWLO = NW'(-WIN_LO);
  localparam logic signed [NW-1:0] SWHI = NW'(WIN_HI);

  typedef enum logic [1:0] {S_IDLE, S_EST, S_OUT} state_t;
  state_t state;

  logic [FW-1:0] tgt_q, vco_q;
  logic          pll_q;
  logic [EW-1:0] est_r;
  logic [NW-1:0] num_sh, den_r, quo;
  logic [NW:0]   rem_r;
  logic [CW-1:0] cnt;

  logic [NW:0]   rem_sh, rem_nx;
  logic          ge, last;
  logic [NW-1:0] quo_nx;
  logic [EW-1:0] est_c;
  logic signed [NW-1:0] diff;
  logic          accept;

  assign rem_sh = {rem_r[NW-1:0], num_sh[NW-1]};
  assign ge     = rem_sh >= {1'b0, den_r};
  assign rem_nx = ge ? rem_sh - {1'b0, den_r} : rem_sh;
  assign quo_nx = {quo[NW-2:0], ge};
  assign last   = cnt == CW'(NW - 1);
  assign est_c  = (quo_nx > NW'(EST_MAX)) ? EW'(EST_MAX) : quo_nx[EW-1:0];
  assign diff   = $signed({1'b0, tgt_q}) - $signed({1'b0, quo_nx[FW-1:0]});
  assign accept = !pll_q || (diff >= SWLO && diff < SWHI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      done <= 1'b0;
      sel_code <= '0;
      achieved_khz <= '0;
      need_pll <= 1'b0;
      range_err <= 1'b0;
      tgt_q <= '0; vco_q <= '0; pll_q <= 1'b0; est_r <= '0;
      num_sh <= '0; den_r <= '0; quo <= '0; rem_r <= '0; cnt <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          tgt_q <= target_khz;
          vco_q <= vco_khz;
          pll_q <= pll_attached;
          if (target_khz == FW'(27000) || target_khz == FW'(100000) ||
              target_khz == FW'(108000)) begin
            done <= 1'b1;
            need_pll <= 1'b0;
            range_err <= 1'b0;
            achieved_khz <= target_khz;
            sel_code <= (target_khz == FW'(27000))  ? 32'h100 :
                        (target_khz == FW'(100000)) ? 32'h2100 : 32'h2140;
          end else if (target_khz <= FW'(OFS)) begin
            done <= 1'b1;
            sel_code <= '0;
            achieved_khz <= '0;
            need_pll <= pll_attached;
            range_err <= !pll_attached;
          end else begin
            num_sh <= {vco_khz, 1'b0};
            den_r <= {1'b0, target_khz - FW'(OFS)};
            rem_r <= '0; quo <= '0; cnt <= '0;
            state <= S_EST;
          end
        end
        S_EST, S_OUT: begin
          num_sh <= {num_sh[NW-2:0], 1'b0};
          rem_r <= rem_nx;
          quo <= quo_nx;
          cnt <= cnt + 1'b1;
          if (last && state == S_EST) begin
            if (est_c > EW'(EST_MIN)) begin
              est_r <= est_c;
              num_sh <= {vco_q, 1'b0};
              den_r <= NW'(est_c);
              rem_r <= '0; quo <= '0; cnt <= '0;
              state <= S_OUT;
            end else begin
              done <= 1'b1;
              sel_code <= '0;
              achieved_khz <= '0;
              need_pll <= pll_q;
              range_err <= !pll_q;
              state <= S_IDLE;
            end
          end else if (last) begin
            done <= 1'b1;
            state <= S_IDLE;
            if (accept) begin
              sel_code <= (32'(est_r - EW'(2)) << 16) | 32'h3100;
              achieved_khz <= quo_nx[FW-1:0];
              need_pll <= 1'b0;
              range_err <= 1'b0;
            end else begin
              sel_code <= '0;
              achieved_khz <= '0;
              need_pll <= 1'b1;
              range_err <= 1'b0;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones({need_pll, range_err}) <= 1); // R6
  AST_ERR_NO_PLL: assert property (@(posedge clk) disable iff (!rst_n)
    done && range_err |-> !pll_q && sel_code == 32'h0); // R6
  AST_DIV_FIELD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    done && sel_code[13:12] == 2'b11 |-> sel_code[21:16] > 6'(EST_MIN - 2)); // R5
  AST_DIV_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    done && pll_q && sel_code[13:12] == 2'b11 |->
      ($signed({1'b0, tgt_q}) - $signed({1'b0, achieved_khz})) >= SWLO &&
      ($signed({1'b0, tgt_q}) - $signed({1'b0, achieved_khz})) < SWHI); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_IDLE && !start |=> $stable(sel_code) && $stable(achieved_khz)); // R7
endmodule

// File: tb/clk_src_select_tb.sv
module clk_src_select_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] target_khz = '0, vco_khz = '0;
  logic pll_attached = 1'b0;
  logic done, need_pll, range_err;
  logic [31:0] sel_code, achieved_khz;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  clk_src_select u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .target_khz(target_khz),
    .vco_khz(vco_khz), .pll_attached(pll_attached), .done(done),
    .sel_code(sel_code), .achieved_khz(achieved_khz),
    .need_pll(need_pll), .range_err(range_err));

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model(input longint t, input longint v, input bit p,
                       output longint sel, output longint ach, output bit np, output bit er);
    longint est, a, d;
    sel = 0; ach = 0; np = 0; er = 0;
    if (t == 27000) begin sel = 'h100; ach = t; end
    else if (t == 100000) begin sel = 'h2100; ach = t; end
    else if (t == 108000) begin sel = 'h2140; ach = t; end
    else begin
      est = (t < 3000) ? 0 : (2 * v) / (t - 2999);
      if (est > 65) est = 65;
      if (est > 4) begin
        a = (2 * v) / est;
        d = t - a;
        if (!p || (d >= -2000 && d < 3000)) begin
          sel = ((est - 2) << 16) | 'h3100; ach = a; return;
        end
      end
      if (p) np = 1; else er = 1;
    end
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (done !== 1'b1 && n < 300) begin @(negedge clk); n++; end
    chk(req, "done seen", done, 1);
  endtask

  task automatic run(input string req, input longint t, input longint v, input bit p);
    longint es, ea; bit en, ee;
    model(t, v, p, es, ea, en, ee);
    @(negedge clk);
    target_khz = 32'(t); vco_khz = 32'(v); pll_attached = p; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done(req);
    chk(req, "sel_code", sel_code, es);
    chk(req, "achieved", achieved_khz, ea);
    chk(req, "need_pll", need_pll, en);
    chk(req, "range_err", range_err, ee);
  endtask

  task automatic t_busy_ignore();
    longint es, ea; bit en, ee;
    model(400000, 1600000, 1, es, ea, en, ee);
    @(negedge clk);
    target_khz = 400000; vco_khz = 1600000; pll_attached = 1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    target_khz = 900000; pll_attached = 0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done("R7");
    chk("R7", "busy start ignored sel", sel_code, es);
    chk("R7", "busy start ignored flag", range_err, ee);
    @(negedge clk);
    chk("R7", "done single cycle", done, 0);
    repeat (5) @(negedge clk);
    chk("R7", "sel held", sel_code, es);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8", "done", done, 0);
    chk("R8", "sel_code", sel_code, 0);
    chk("R8", "achieved", achieved_khz, 0);
    chk("R8", "flags", {need_pll, range_err}, 0);
    rst_n = 1'b1;
    run("R1", 27000, 1600000, 1);
    run("R1", 100000, 1600000, 0);
    run("R1", 108000, 1600000, 1);
    run("R5", 400000, 1600000, 1);
    run("R5", 27001, 1600000, 1);
    run("R2", 20000, 1600000, 0);
    run("R2", 2000, 1600000, 1);
    run("R6", 2999, 1600000, 0);
    run("R3", 900000, 1600000, 1);
    run("R6", 900000, 1600000, 0);
    run("R4", 398000, 1600000, 1);
    run("R4", 397999, 1600000, 1);
    run("R4", 397999, 1600000, 0);
    run("R4", 402999, 1600000, 1);
    run("R6", 405000, 1600000, 1);
    run("R3", 150000, 1000000, 1);
    t_busy_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule